// File: doc/BRIEF.md
# Serial Bus Word Error Classifier

This block watches one channel of a dual-redundant 1 Mbit/s Manchester II command/response bus and turns the line activity into classified words. It samples the channel once per half-bit. It finds the 3-bit-time sync in either polarity and shifts in sixteen data bits and a parity bit. Each word is then presented with its sync type, its data, a ten-bit error vector and a 32-bit microsecond time tag, all on a single-cycle strobe.

The error vector does more than mark a word good or bad. A short word reports how many bits are missing, and a long word reports how many extra bits followed it. A bit cell with no mid-bit transition is reported as stuck high or stuck low. The vector also flags a sync whose polarity does not suit the word's place in the message, a data word that arrives after a gap, and any activity on the companion channel while the word is on the bus. A monitor stores each strobed word next to its annotation.

The line decoder samples each channel as two polarity wires (positive and negative half). A half-bit is high when only the positive wire is set, low when only the negative wire is set, and idle otherwise. The half-bit period is `HALF_CLKS` clock cycles.

Top module: `bus_word_classifier`

## Requirements
- R1: The half-bit sequence high,high,high,low,low,low is a command/status sync (`word_is_data`=0), and low,low,low,high,high,high is a data sync (`word_is_data`=1). A bit cell of high-then-low is a 1 and low-then-high is a 0. The first data bit received is `word_data[15]`.
- R2: On a word with all 17 bits, `word_err[4]` is set when the 16 data bits and the parity bit together hold an even number of ones.
- R3: A word that goes idle before its 17th bit reports the missing bit count in `word_err[1:0]` (1, 2, or 3 for three or more). Its received bits are left-justified in `word_data` with zeros after them, and `word_err[4]` stays clear.
- R4: Non-idle half-bits that follow the parity bit and do not form a sync are reported as extra bits in `word_err[3:2]`. The count is half the number of such half-bits, rounded up and capped at 3. After six such half-bits the word is closed with a count of 3.
- R5: A complete bit cell of high,high sets `word_err[6]`, and one of low,low sets `word_err[5]`. Either cell is taken as a 0.
- R6: A sync that starts on the half-bit directly after a parity bit closes that word with no extra-bit count and opens a new word whose gap is zero.
- R7: `word_err[7]` (inverted sync) is set on a command/status-sync word whose preceding idle gap is under `GAP_HALVES` half-bits (default 4, 2 µs).
- R8: `word_err[8]` (non-contiguous) is set on a data-sync word whose preceding idle gap is `GAP_HALVES` half-bits or more. The half-bit that ended the previous word counts in the gap, and the gap is taken as saturated after reset.
- R9: `word_err[9]` is set when the other channel shows a non-idle half-bit at any half-bit sample from the six sync halves through the half-bit that closes the word.
- R10: `word_tag` is the value of a microsecond counter, cleared by reset and stepped every second half-bit, at the half-bit on which the word's sync completed.
- R11: During reset and until the first word, `word_valid` is 0 and every word output is 0.
- R12: `word_valid` is high for exactly one clock per word, in the cycle after the half-bit sample that closes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_a_pos | input | 1 | Monitored channel, positive half |
| rx_a_neg | input | 1 | Monitored channel, negative half |
| rx_b_pos | input | 1 | Companion channel, positive half |
| rx_b_neg | input | 1 | Companion channel, negative half |
| word_valid | output | 1 | One-cycle strobe for a classified word |
| word_is_data | output | 1 | Sync type: 1 data, 0 command/status |
| word_data | output | 16 | Received data bits |
| word_err | output | 10 | Error vector as listed in the requirements |
| word_tag | output | 32 | Microsecond time tag |

## Verification
A wrong framing state mostly shows up as a word strobed on the wrong half-bit or not strobed at all. The bench model expects every strobe on one exact cycle, so such a fault is caught on the first word it touches. A wrong gap count or wrong sync history changes bits 7 and 8 of the next word only. A broken bit counter shifts the data and the low/high counts of the word in flight. A time base that is off moves every later tag, so one word after the fault is enough to reveal it.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        SYM_IDLE = 2'd0,
        SYM_HIGH = 2'd1,
        SYM_LOW  = 2'd2
    } sym_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2
    } fsm_t;

    localparam int DATA_BITS   = 16;
    localparam int WORD_BITS   = DATA_BITS + 1;
    localparam int SYNC_HALVES = 6;
    localparam int HIST_W      = 2 * SYNC_HALVES;
    localparam int ERR_W       = 10;

    // oldest half-bit sits in the top pair
    localparam logic [HIST_W-1:0] PAT_CMD  = 12'b01_01_01_10_10_10;
    localparam logic [HIST_W-1:0] PAT_DATA = 12'b10_10_10_01_01_01;

    typedef struct packed {
        logic       dual;
        logic       noncontig;
        logic       inv_sync;
        logic       man_high;
        logic       man_low;
        logic       parity;
        logic [1:0] high_cnt;
        logic [1:0] low_cnt;
    } werr_t;

    function automatic sym_t line_sym(input logic p, input logic n);
        if (p && !n)      return SYM_HIGH;
        else if (n && !p) return SYM_LOW;
        else              return SYM_IDLE;
    endfunction

    // bit 0: command/status sync, bit 1: data sync
    function automatic logic [1:0] sync_kind(input logic [HIST_W-1:0] h);
        return {h == PAT_DATA, h == PAT_CMD};
    endfunction

endpackage

// File: rtl/bwc_line_decode.sv
module bwc_line_decode
    import bwc_pkg::*;
(
    input  logic pos,
    input  logic neg,
    output sym_t sym,
    output logic active
);
    assign sym    = line_sym(pos, neg);
    assign active = (sym != SYM_IDLE);
endmodule

// File: rtl/bwc_timebase.sv
module bwc_timebase #(
    parameter int HALF_CLKS = 125,
    parameter int TAG_W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic             half_tick,
    output logic [TAG_W-1:0] usec
);
    localparam int DIV_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [DIV_W-1:0] div;
    logic             phase;

    assign half_tick = (div == DIV_W'(HALF_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div   <= '0;
            phase <= 1'b0;
            usec  <= '0;
        end else begin
            div <= half_tick ? '0 : div + 1'b1;
            if (half_tick) begin
                phase <= ~phase;
                if (phase) usec <= usec + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bwc_framer.sv
module bwc_framer
    import bwc_pkg::*;
#(
    parameter int TAG_W      = 32,
    parameter int ZCNT_W     = 8,
    parameter int GAP_HALVES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 half_tick,
    input  sym_t                 sym_a,
    input  logic                 act_b,
    input  logic [TAG_W-1:0]     usec,
    output logic                 out_valid,
    output logic                 out_is_data,
    output logic [DATA_BITS-1:0] out_data,
    output werr_t                out_err,
    output logic [TAG_W-1:0]     out_tag
);
    localparam int NB_W = $clog2(WORD_BITS + 1);

    fsm_t                    st, st_n;
    logic [HIST_W-1:0]       hist, hist_n;
    logic [SYNC_HALVES-1:0]  bhist, bhist_n;
    logic [ZCNT_W-1:0]       zcnt, gap_use;
    logic [NB_W-1:0]         nb, miss;
    logic [WORD_BITS-1:0]    shreg, sh_n, lj;
    logic [2:0]              tcnt, tp1;
    logic [1:0]              kind_n, e_low, e_high;
    sym_t                    first;
    logic                    second, mhi, mlo, bflag, bflag_n;
    logic                    cur_data, cur_inv, cur_nc;
    logic [TAG_W-1:0]        cur_tag;
    logic                    do_start, do_emit, e_full;

    always_comb begin
        hist_n  = {hist[HIST_W-3:0], sym_a};
        bhist_n = {bhist[SYNC_HALVES-2:0], act_b};
        kind_n  = sync_kind(hist_n);
        bflag_n = bflag | act_b;
        sh_n    = {shreg[WORD_BITS-2:0], (first == SYM_HIGH) && (sym_a == SYM_LOW)};
        miss    = NB_W'(WORD_BITS) - nb;
        lj      = shreg << miss;
        tp1     = tcnt + 3'd1;
    end

    always_comb begin
        st_n     = st;
        do_start = 1'b0;
        do_emit  = 1'b0;
        e_full   = 1'b0;
        e_low    = 2'd0;
        e_high   = 2'd0;
        gap_use  = zcnt;
        unique case (st)
            ST_HUNT: if (kind_n != 2'b00) begin
                do_start = 1'b1;
                st_n     = ST_BODY;
            end
            ST_BODY: if (sym_a == SYM_IDLE) begin
                do_emit = 1'b1;
                e_low   = (miss >= NB_W'(3)) ? 2'd3 : miss[1:0];
                st_n    = ST_HUNT;
            end else if (second && nb == NB_W'(WORD_BITS - 1)) begin
                st_n = ST_TAIL;
            end
            ST_TAIL: if (sym_a == SYM_IDLE) begin
                do_emit = 1'b1;
                e_full  = 1'b1;
                e_high  = tp1[2:1];
                st_n    = ST_HUNT;
            end else if (tcnt == 3'(SYNC_HALVES - 1)) begin
                do_emit = 1'b1;
                e_full  = 1'b1;
                if (kind_n != 2'b00) begin
                    do_start = 1'b1;
                    gap_use  = '0;
                    st_n     = ST_BODY;
                end else begin
                    e_high = 2'd3;
                    st_n   = ST_HUNT;
                end
            end
            default: st_n = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_HUNT;
            hist        <= '0;
            bhist       <= '0;
            zcnt        <= '1;
            nb          <= '0;
            shreg       <= '0;
            tcnt        <= '0;
            first       <= SYM_IDLE;
            second      <= 1'b0;
            mhi         <= 1'b0;
            mlo         <= 1'b0;
            bflag       <= 1'b0;
            cur_data    <= 1'b0;
            cur_inv     <= 1'b0;
            cur_nc      <= 1'b0;
            cur_tag     <= '0;
            out_valid   <= 1'b0;
            out_is_data <= 1'b0;
            out_data    <= '0;
            out_err     <= '0;
            out_tag     <= '0;
        end else begin
            out_valid <= 1'b0;
            if (half_tick) begin
                hist  <= hist_n;
                bhist <= bhist_n;
                st    <= st_n;
                bflag <= bflag_n;
                if (st == ST_HUNT && sym_a == SYM_IDLE && zcnt != '1)
                    zcnt <= zcnt + 1'b1;
                if (st == ST_BODY && sym_a != SYM_IDLE) begin
                    if (!second) begin
                        first  <= sym_a;
                        second <= 1'b1;
                    end else begin
                        second <= 1'b0;
                        shreg  <= sh_n;
                        nb     <= nb + 1'b1;
                        mhi    <= mhi | (first == SYM_HIGH && sym_a == SYM_HIGH);
                        mlo    <= mlo | (first == SYM_LOW && sym_a == SYM_LOW);
                    end
                end
                if (st == ST_TAIL && sym_a != SYM_IDLE)
                    tcnt <= tp1;
                if (do_emit) begin
                    out_valid          <= 1'b1;
                    out_is_data        <= cur_data;
                    out_data           <= e_full ? shreg[WORD_BITS-1:1] : lj[WORD_BITS-1:1];
                    out_tag            <= cur_tag;
                    out_err.low_cnt    <= e_low;
                    out_err.high_cnt   <= e_high;
                    out_err.parity     <= e_full & ~(^shreg);
                    out_err.man_low    <= mlo;
                    out_err.man_high   <= mhi;
                    out_err.inv_sync   <= cur_inv;
                    out_err.noncontig  <= cur_nc;
                    out_err.dual       <= bflag_n;
                    zcnt               <= (sym_a == SYM_IDLE) ? ZCNT_W'(1) : '0;
                end
                if (do_start) begin
                    nb       <= '0;
                    shreg    <= '0;
                    second   <= 1'b0;
                    tcnt     <= '0;
                    mhi      <= 1'b0;
                    mlo      <= 1'b0;
                    bflag    <= |bhist_n;
                    cur_data <= kind_n[1];
                    cur_inv  <= kind_n[0] && (gap_use < ZCNT_W'(GAP_HALVES));
                    cur_nc   <= kind_n[1] && (gap_use >= ZCNT_W'(GAP_HALVES));
                    cur_tag  <= usec;
                    zcnt     <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/bus_word_classifier.sv
module bus_word_classifier
    import bwc_pkg::*;
#(
    parameter int HALF_CLKS  = 125,
    parameter int TAG_W      = 32,
    parameter int ZCNT_W     = 8,
    parameter int GAP_HALVES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_a_pos,
    input  logic                 rx_a_neg,
    input  logic                 rx_b_pos,
    input  logic                 rx_b_neg,
    output logic                 word_valid,
    output logic                 word_is_data,
    output logic [DATA_BITS-1:0] word_data,
    output logic [ERR_W-1:0]     word_err,
    output logic [TAG_W-1:0]     word_tag
);
    localparam int N_CH = 2;

    logic [N_CH-1:0]  ln_pos, ln_neg, ch_act;
    sym_t             ch_sym [N_CH];
    logic             half_tick;
    logic [TAG_W-1:0] usec;
    werr_t            err_s;

    assign ln_pos = {rx_b_pos, rx_a_pos};
    assign ln_neg = {rx_b_neg, rx_a_neg};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        bwc_line_decode u_dec (
            .pos    (ln_pos[c]),
            .neg    (ln_neg[c]),
            .sym    (ch_sym[c]),
            .active (ch_act[c])
        );
    end

    bwc_timebase #(.HALF_CLKS(HALF_CLKS), .TAG_W(TAG_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .usec      (usec)
    );

    bwc_framer #(.TAG_W(TAG_W), .ZCNT_W(ZCNT_W), .GAP_HALVES(GAP_HALVES)) u_fr (
        .clk         (clk),
        .rst         (rst),
        .half_tick   (half_tick),
        .sym_a       (ch_sym[0]),
        .act_b       (ch_act[1]),
        .usec        (usec),
        .out_valid   (word_valid),
        .out_is_data (word_is_data),
        .out_data    (word_data),
        .out_err     (err_s),
        .out_tag     (word_tag)
    );

    assign word_err = err_s;
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker (
    input logic       clk,
    input logic       rst,
    input logic       word_valid,
    input logic       word_is_data,
    input logic [9:0] word_err
);
    // R12: strobe lasts one clock
    assert_strobe_single_R12: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R11: no strobe in the cycle after reset
    assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !word_valid);

    // R3 / R4: a word is short or long, never both
    assert_low_high_excl_R4: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (word_err[1:0] == 2'd0 || word_err[3:2] == 2'd0));

    // R3: short words carry no parity verdict
    assert_short_no_parity_R3: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_err[1:0] != 2'd0) |-> !word_err[4]);

    // R7: inverted sync only on command/status sync
    assert_inv_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_err[7]) |-> !word_is_data);

    // R8: non-contiguous only on data sync
    assert_nc_data_R8: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_err[8]) |-> word_is_data);
endmodule

bind bus_word_classifier bwc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .word_valid   (word_valid),
    .word_is_data (word_is_data),
    .word_err     (word_err)
);

// File: tb/bus_word_classifier_tb.sv
module bus_word_classifier_tb;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_pos = 0, a_neg = 0, b_pos = 0, b_neg = 0;
    logic        d_valid, d_isd;
    logic [15:0] d_data;
    logic [9:0]  d_err;
    logic [31:0] d_tag;

    int total = 0, bad = 0, words = 0;
    bit done = 0;
    bit b_on = 0;

    always #2 clk = ~clk;   // 250 MHz

    bus_word_classifier #(.HALF_CLKS(HALF)) u_dut (
        .clk(clk), .rst(rst),
        .rx_a_pos(a_pos), .rx_a_neg(a_neg), .rx_b_pos(b_pos), .rx_b_neg(b_neg),
        .word_valid(d_valid), .word_is_data(d_isd), .word_data(d_data),
        .word_err(d_err), .word_tag(d_tag)
    );

    // ---------------- behavioural reference model ----------------
    int          mdiv, mst, zc, tn;
    bit          mphase, cur_d, cur_inv, cur_nc, bfl;
    logic [31:0] mtime, cur_tag;
    int          hist[$], bh[$], body[$];
    logic        m_valid, m_isd;
    logic [15:0] m_data;
    logic [9:0]  m_err;
    logic [31:0] m_tag;

    function automatic int kind_of(int q[$]);
        if (q.size() < 6) return 0;
        if (q[0]==1 && q[1]==1 && q[2]==1 && q[3]==2 && q[4]==2 && q[5]==2) return 1;
        if (q[0]==2 && q[1]==2 && q[2]==2 && q[3]==1 && q[4]==1 && q[5]==1) return 2;
        return 0;
    endfunction

    task automatic m_start(int k, int gap);
        cur_d   = (k == 2);
        cur_inv = (k == 1) && gap < 4;
        cur_nc  = (k == 2) && gap >= 4;
        cur_tag = mtime;
        bfl = 0;
        foreach (bh[i]) if (bh[i] != 0) bfl = 1;
        body.delete();
        tn  = 0;
        mst = 1;
    endtask

    task automatic m_emit(bit full, int high, bit dual);
        int nbits, ones, lo;
        bit mh, ml, bv;
        nbits = body.size() / 2;
        ones = 0; mh = 0; ml = 0;
        m_data = '0;
        for (int i = 0; i < nbits; i++) begin
            bv = (body[2*i] == 1 && body[2*i+1] == 2);
            if (body[2*i] == 1 && body[2*i+1] == 1) mh = 1;
            if (body[2*i] == 2 && body[2*i+1] == 2) ml = 1;
            if (bv) ones++;
            if (i < 16) m_data[15-i] = bv;
        end
        lo = full ? 0 : ((17 - nbits) >= 3 ? 3 : 17 - nbits);
        m_err   = {dual, cur_nc, cur_inv, mh, ml, full && (ones % 2 == 0), 2'(high), 2'(lo)};
        m_valid = 1;
        m_isd   = cur_d;
        m_tag   = cur_tag;
    endtask

    always @(posedge clk) begin
        int s, k;
        bit b, bn;
        if (rst) begin
            mdiv = 0; mphase = 0; mtime = 0; mst = 0; zc = 255; tn = 0; bfl = 0;
            hist.delete(); bh.delete(); body.delete();
            m_valid = 0; m_isd = 0; m_data = 0; m_err = 0; m_tag = 0;
            cur_d = 0; cur_inv = 0; cur_nc = 0; cur_tag = 0;
        end else begin
            m_valid = 0;
            if (mdiv == HALF - 1) begin
                mdiv = 0;
                s = (a_pos && !a_neg) ? 1 : ((a_neg && !a_pos) ? 2 : 0);
                b = b_pos ^ b_neg;
                hist.push_back(s); if (hist.size() > 6) void'(hist.pop_front());
                bh.push_back(int'(b)); if (bh.size() > 6) void'(bh.pop_front());
                bn = bfl | b;
                case (mst)
                    0: begin
                        if (s == 0 && zc < 255) zc++;
                        k = kind_of(hist);
                        if (k != 0) m_start(k, zc);
                    end
                    1: begin
                        if (s == 0) begin m_emit(0, 0, bn); mst = 0; zc = 1; end
                        else begin
                            body.push_back(s);
                            if (body.size() == 34) begin mst = 2; tn = 0; end
                            bfl = bn;
                        end
                    end
                    default: begin
                        if (s == 0) begin m_emit(1, (tn + 1) / 2, bn); mst = 0; zc = 1; end
                        else begin
                            tn++;
                            bfl = bn;
                            if (tn == 6) begin
                                k = kind_of(hist);
                                if (k != 0) begin m_emit(1, 0, bn); m_start(k, 0); end
                                else begin m_emit(1, 3, bn); mst = 0; zc = 0; end
                            end
                        end
                    end
                endcase
                if (mphase) mtime++;
                mphase = !mphase;
            end else begin
                mdiv++;
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            if (!done && $time > 4 && $time < 12) begin
                chk("R11 valid in reset", 32'(d_valid), 0);
                chk("R11 data in reset", 32'(d_data), 0);
                chk("R11 err in reset", 32'(d_err), 0);
                chk("R11 tag in reset", d_tag, 0);
            end
        end else if (!done) begin
            if (d_valid !== m_valid) chk("R12 strobe timing", 32'(d_valid), 32'(m_valid));
            else if (m_valid) begin
                words++;
                chk("R1 sync type", 32'(d_isd), 32'(m_isd));
                chk("R1 data", 32'(d_data), 32'(m_data));
                chk("R3 low count", 32'(d_err[1:0]), 32'(m_err[1:0]));
                chk("R4 R6 high count", 32'(d_err[3:2]), 32'(m_err[3:2]));
                chk("R2 parity", 32'(d_err[4]), 32'(m_err[4]));
                chk("R5 stuck low", 32'(d_err[5]), 32'(m_err[5]));
                chk("R5 stuck high", 32'(d_err[6]), 32'(m_err[6]));
                chk("R7 inverted sync", 32'(d_err[7]), 32'(m_err[7]));
                chk("R8 noncontiguous", 32'(d_err[8]), 32'(m_err[8]));
                chk("R9 dual channel", 32'(d_err[9]), 32'(m_err[9]));
                chk("R10 time tag", d_tag, m_tag);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic half(int s);
        a_pos = (s == 1);
        a_neg = (s == 2);
        b_pos = b_on;
        b_neg = 0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) half(0);
    endtask

    task automatic send_word(bit isd, logic [15:0] d, int nbits, bit bad_par,
                             int man_idx, int man_s, int extra);
        bit p, bv;
        p = ~(^d) ^ bad_par;
        for (int i = 0; i < 3; i++) half(isd ? 2 : 1);
        for (int i = 0; i < 3; i++) half(isd ? 1 : 2);
        for (int i = 0; i < nbits; i++) begin
            bv = (i < 16) ? d[15-i] : p;
            if (i == man_idx) begin half(man_s); half(man_s); end
            else if (bv) begin half(1); half(2); end
            else begin half(2); half(1); end
        end
        for (int j = 0; j < extra; j++) half((j % 2 == 0) ? 1 : 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        idle(10);
        // R1 R2 R10: clean command word, then R6 contiguous data word
        send_word(0, 16'hA5C3, 17, 0, -1, 0, 0);
        send_word(1, 16'h0001, 17, 0, -1, 0, 0);
        // R7: command sync directly after a word
        send_word(0, 16'h1234, 17, 0, -1, 0, 0);
        idle(3);
        send_word(1, 16'hFFFF, 17, 0, -1, 0, 0);   // gap below limit
        idle(4);
        send_word(1, 16'h0F0F, 17, 0, -1, 0, 0);   // R8
        idle(8);
        send_word(0, 16'h5555, 17, 1, -1, 0, 0);   // R2 bad parity
        idle(8);
        send_word(0, 16'hBEEF, 15, 0, -1, 0, 0);   // R3 two missing
        idle(8);
        send_word(1, 16'hC001, 16, 0, -1, 0, 0);   // R3 one missing
        idle(8);
        send_word(0, 16'hFFFF, 10, 0, -1, 0, 0);   // R3 saturated
        idle(8);
        send_word(0, 16'h8421, 17, 0, -1, 0, 4);   // R4 two extra
        idle(8);
        send_word(1, 16'h7E7E, 17, 0, -1, 0, 1);   // R4 one extra
        idle(8);
        send_word(0, 16'h0000, 17, 0, -1, 0, 6);   // R4 saturated
        idle(8);
        send_word(0, 16'hFFFF, 17, 0, 3, 1, 0);    // R5 stuck high
        idle(8);
        send_word(1, 16'h0000, 17, 0, 12, 2, 0);   // R5 stuck low
        idle(8);
        b_on = 1;
        send_word(0, 16'h3C3C, 17, 0, -1, 0, 0);   // R9 active
        b_on = 0;
        idle(8);
        b_on = 1; idle(4); b_on = 0; idle(7);
        send_word(0, 16'h1111, 17, 0, -1, 0, 0);   // R9 activity only before
        idle(20);
        chk("R12 word count", 32'(words), 32'd16);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule